// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery and Claim Unit

This unit sits between an interrupt source unit and a set of harts. The source unit supplies one pending bit and one enable bit per source. Each source carries a target word that names the hart it is routed to and its priority. For each hart, the unit picks the best eligible source and drives that hart's interrupt line. Software claims the winning source through a per-hart claim register, and the unit then sends a claim-clear strobe back to the source unit.

Each hart has a small control slice with four fields: a delivery enable, a force bit, a priority threshold, and a top-interrupt register. The top-interrupt register shows the current winner and has no side effects when read. Register access uses a plain strobe port with a byte address. A read returns data one cycle after the strobe. A domain-wide enable input gates every hart line.

Top module: `ihd_top`

## Requirements
- R1: The target word of source i (1-based) is at byte address 0x3004 + (i-1)*4. The hart index is held from bit 18 upward, keeping only the low log2(harts) bits. The priority is held in bits 7:0. The word reads back as written, with all other bits zero.
- R2: Writing a priority of 0 stores and reads back a priority of 1.
- R3: For each hart, the winner is chosen from the sources that are pending, enabled and routed to that hart. The smallest priority number wins. On equal priority, the lower source number wins.
- R4: A threshold of 0 makes every priority eligible. A non-zero threshold T admits only sources whose priority is strictly less than T.
- R5: The top-interrupt register holds the winner's source number in bits 25:16 and its priority in bits 7:0. It reads as 0 when there is no winner. Reading it raises no claim strobe and changes no state.
- R6: A claim register read returns the same word as the top-interrupt register. When the source number is non-zero, the same read raises `claimValid` for exactly one cycle, with `claimSrc` set to that source number.
- R7: Any claim read clears that hart's force bit. A claim read with no winner returns 0 and raises no claim strobe.
- R8: Each hart output is registered. It equals delivery-enable AND (winner exists OR force) AND `domainEn`, as seen one clock earlier. All outputs are 0 after reset.
- R9: Hart h's control slice starts at byte address 0x4000 + h*0x20. Its fields are at these offsets:
  - delivery enable (bit 0) at +0x00
  - force (bit 0) at +0x04
  - threshold (bits 7:0) at +0x08
  - top-interrupt at +0x18
  - claim at +0x1C

  The first three fields are read/write.
- R10: Read data appears on `regRdData` in the cycle after the read strobe. It is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after the read strobe |
| pendVec | input | NUM_SRC | Pending bits; bit k is source k+1 |
| enVec | input | NUM_SRC | Enable bits; bit k is source k+1 |
| domainEn | input | 1 | Domain-wide delivery enable |
| hartIrq | output | NUM_HART | One interrupt line per hart |
| claimValid | output | 1 | One-cycle claim-clear strobe to the source unit |
| claimSrc | output | 10 | Source number being claimed |

## Verification
Three results each arrive one clock after their cause:
- Read data and the claim strobe are registered on the edge that samples the read strobe.
- Each hart line is registered on the edge that samples a change in pending bits, control fields or `domainEn`.

The bench drives every input on the falling edge. Each read task captures data on the next falling edge, which falls inside the single valid cycle. After any change that affects a hart line, the bench waits one more falling edge before sampling.

The arbitration model in the bench sweeps every pending pattern over seven sources with tied priorities. It then sweeps several thresholds and both hart routings.

// File: rtl/ihd_pkg.sv
package ihd_pkg;
  localparam int SRC_NUM_W  = 10;
  localparam int HART_NUM_W = 14;
  localparam int TGT_BASE   = 32'h3004;
  localparam int IDC_BASE   = 32'h4000;
  localparam int IDC_STRIDE = 32'h20;
  localparam int HART_LSB   = 18;
  localparam int SRC_LSB    = 16;

  typedef enum logic [2:0] {
    F_NONE, F_TGT, F_DELIV, F_FORCE, F_THRESH, F_TOPI, F_CLAIM
  } field_e;

  typedef struct packed {
    logic                  wrEn;
    logic                  rdEn;
    field_e                field;
    logic [SRC_NUM_W-1:0]  srcIdx;
    logic [HART_NUM_W-1:0] hartSel;
  } strobe_t;
endpackage

// File: rtl/ihd_ctrl.sv
module ihd_ctrl
  import ihd_pkg::*;
#(
  parameter int NUM_SRC  = 7,
  parameter int NUM_HART = 2,
  parameter int ADDR_W   = 15
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);
  localparam int TGT_END = TGT_BASE + NUM_SRC * 4;
  localparam int IDC_END = IDC_BASE + NUM_HART * IDC_STRIDE;

  logic [31:0] addr;
  logic [31:0] tgtRel;
  logic [31:0] idcRel;
  logic        tgtHit;
  logic        idcHit;

  assign addr   = 32'(regAddr);
  assign tgtRel = addr - 32'(TGT_BASE);
  assign idcRel = addr - 32'(IDC_BASE);
  assign tgtHit = (addr >= 32'(TGT_BASE)) && (addr < 32'(TGT_END)) && (addr[1:0] == 2'b00);
  assign idcHit = (addr >= 32'(IDC_BASE)) && (addr < 32'(IDC_END));

  always_comb begin
    stb.wrEn    = regWrEn;
    stb.rdEn    = regRdEn;
    stb.field   = F_NONE;
    stb.srcIdx  = '0;
    stb.hartSel = '0;
    if (tgtHit) begin
      stb.field  = F_TGT;
      stb.srcIdx = SRC_NUM_W'((tgtRel >> 2) + 32'd1);
    end else if (idcHit) begin
      stb.hartSel = HART_NUM_W'(idcRel >> 5);
      case (idcRel[4:0])
        5'h00:   stb.field = F_DELIV;
        5'h04:   stb.field = F_FORCE;
        5'h08:   stb.field = F_THRESH;
        5'h18:   stb.field = F_TOPI;
        5'h1C:   stb.field = F_CLAIM;
        default: stb.field = F_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ihd_datapath.sv
module ihd_datapath
  import ihd_pkg::*;
#(
  parameter int NUM_SRC  = 7,
  parameter int NUM_HART = 2,
  parameter int PRIO_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [31:0]          wrData,
  input  logic [NUM_SRC-1:0]   pendVec,
  input  logic [NUM_SRC-1:0]   enVec,
  input  logic                 domainEn,
  output logic [NUM_HART-1:0]  hartIrq,
  output logic [31:0]          rdData,
  output logic                 claimValid,
  output logic [SRC_NUM_W-1:0] claimSrc
);
  localparam int HART_W = (NUM_HART > 1) ? $clog2(NUM_HART) : 1;
  localparam logic [PRIO_W-1:0] PRIO_MIN = PRIO_W'(1);

  logic [HART_W-1:0] tgtHart [NUM_SRC];
  logic [PRIO_W-1:0] tgtPrio [NUM_SRC];
  logic [NUM_HART-1:0] deliv;
  logic [NUM_HART-1:0] forceBit;
  logic [PRIO_W-1:0] thresh [NUM_HART];

  logic [NUM_HART-1:0]  hasBest;
  logic [SRC_NUM_W-1:0] bestSrc  [NUM_HART];
  logic [31:0]          topiWord [NUM_HART];

  // Target words
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!rstN) begin
        tgtHart[i] <= '0;
        tgtPrio[i] <= PRIO_MIN;
      end else if (stb.wrEn && stb.field == F_TGT && stb.srcIdx == SRC_NUM_W'(i + 1)) begin
        tgtHart[i] <= wrData[HART_LSB +: HART_W];
        tgtPrio[i] <= (wrData[PRIO_W-1:0] == '0) ? PRIO_MIN : wrData[PRIO_W-1:0];
      end
    end
  end

  // Per-hart control slices and arbiters
  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    logic                 sel;
    logic                 found;
    logic [SRC_NUM_W-1:0] bSrc;
    logic [PRIO_W-1:0]    bPrio;

    assign sel = (stb.hartSel == HART_NUM_W'(h));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        deliv[h]    <= 1'b0;
        forceBit[h] <= 1'b0;
        thresh[h]   <= '0;
      end else begin
        if (stb.wrEn && sel && stb.field == F_DELIV) deliv[h] <= wrData[0];
        if (stb.wrEn && sel && stb.field == F_THRESH) thresh[h] <= wrData[PRIO_W-1:0];
        if (stb.rdEn && sel && stb.field == F_CLAIM) forceBit[h] <= 1'b0;
        else if (stb.wrEn && sel && stb.field == F_FORCE) forceBit[h] <= wrData[0];
      end
    end

    always_comb begin
      found = 1'b0;
      bSrc  = '0;
      bPrio = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (pendVec[i] && enVec[i] && tgtHart[i] == HART_W'(h) &&
            (thresh[h] == '0 || tgtPrio[i] < thresh[h]) &&
            (!found || tgtPrio[i] < bPrio)) begin
          found = 1'b1;
          bSrc  = SRC_NUM_W'(i + 1);
          bPrio = tgtPrio[i];
        end
      end
    end

    assign hasBest[h] = found;
    assign bestSrc[h] = bSrc;

    always_comb begin
      topiWord[h] = '0;
      topiWord[h][SRC_LSB +: SRC_NUM_W] = bSrc;
      topiWord[h][PRIO_W-1:0] = bPrio;
    end

    always_ff @(posedge clk) begin
      if (!rstN) hartIrq[h] <= 1'b0;
      else       hartIrq[h] <= deliv[h] && (found || forceBit[h]) && domainEn;
    end
  end

  // Read mux and claim strobe
  logic [31:0]          rdNext;
  logic                 claimNext;
  logic [SRC_NUM_W-1:0] claimNextSrc;

  always_comb begin
    rdNext       = '0;
    claimNext    = 1'b0;
    claimNextSrc = '0;
    if (stb.rdEn) begin
      if (stb.field == F_TGT) begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (stb.srcIdx == SRC_NUM_W'(i + 1)) begin
            rdNext[HART_LSB +: HART_W] = tgtHart[i];
            rdNext[PRIO_W-1:0]         = tgtPrio[i];
          end
        end
      end else begin
        for (int h = 0; h < NUM_HART; h++) begin
          if (stb.hartSel == HART_NUM_W'(h)) begin
            case (stb.field)
              F_DELIV:  rdNext[0] = deliv[h];
              F_FORCE:  rdNext[0] = forceBit[h];
              F_THRESH: rdNext[PRIO_W-1:0] = thresh[h];
              F_TOPI:   rdNext = topiWord[h];
              F_CLAIM: begin
                rdNext       = topiWord[h];
                claimNext    = hasBest[h];
                claimNextSrc = bestSrc[h];
              end
              default:  rdNext = '0;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData     <= '0;
      claimValid <= 1'b0;
      claimSrc   <= '0;
    end else begin
      rdData     <= rdNext;
      claimValid <= claimNext;
      claimSrc   <= claimNextSrc;
    end
  end
endmodule

// File: rtl/ihd_top.sv
module ihd_top
  import ihd_pkg::*;
#(
  parameter int NUM_SRC  = 7,
  parameter int NUM_HART = 2,
  parameter int PRIO_W   = 8,
  parameter int ADDR_W   = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_SRC-1:0]  pendVec,
  input  logic [NUM_SRC-1:0]  enVec,
  input  logic                domainEn,
  output logic [NUM_HART-1:0] hartIrq,
  output logic                claimValid,
  output logic [9:0]          claimSrc
);
  strobe_t stb;

  ihd_ctrl #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .stb(stb)
  );

  ihd_datapath #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .pendVec(pendVec), .enVec(enVec), .domainEn(domainEn),
    .hartIrq(hartIrq), .rdData(regRdData),
    .claimValid(claimValid), .claimSrc(claimSrc)
  );
endmodule

// File: rtl/ihd_checker.sv
module ihd_checker #(
  parameter int NUM_SRC  = 7,
  parameter int NUM_HART = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                regRdEn,
  input logic [31:0]         regRdData,
  input logic [NUM_SRC-1:0]  pendVec,
  input logic [NUM_SRC-1:0]  enVec,
  input logic                domainEn,
  input logic [NUM_HART-1:0] hartIrq,
  input logic                claimValid,
  input logic [9:0]          claimSrc
);
  assert_domain_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !domainEn |=> hartIrq == '0);

  assert_claim_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    claimValid |-> (claimSrc != 10'd0 && claimSrc <= 10'(NUM_SRC)));

  assert_claim_follows_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    claimValid |-> $past(regRdEn));

  assert_claim_had_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    claimValid |-> ($past(pendVec & enVec) != '0));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> regRdData == 32'd0);
endmodule

bind ihd_top ihd_checker #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART)) u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regRdData(regRdData),
  .pendVec(pendVec), .enVec(enVec), .domainEn(domainEn), .hartIrq(hartIrq),
  .claimValid(claimValid), .claimSrc(claimSrc)
);

// File: tb/ihd_top_bench.sv
`timescale 1ns/1ps
module ihd_top_bench;
  localparam int NS = 7;
  localparam int NH = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [14:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NS-1:0] pendVec = '0, enVec = '0;
  logic        domainEn = 1'b1;
  logic [NH-1:0] hartIrq;
  logic        claimValid;
  logic [9:0]  claimSrc;

  int checks = 0, errors = 0;
  bit done = 0;
  int bPrio [1:NS];
  int bHart [1:NS];
  int thr [NH];

  always #2.5 clk = ~clk;

  ihd_top u_ihd_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pendVec(pendVec), .enVec(enVec), .domainEn(domainEn),
    .hartIrq(hartIrq), .claimValid(claimValid), .claimSrc(claimSrc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 15'(addr); regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // R10: data is taken on the falling edge right after the strobe's clock edge
  task automatic rd(input int addr, output logic [31:0] data, output logic cv, output logic [9:0] cs);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 15'(addr);
    @(negedge clk);
    regRdEn = 1'b0;
    data = regRdData; cv = claimValid; cs = claimSrc;
  endtask

  function automatic logic [31:0] expTop(input int h, input logic [NS-1:0] p, input logic [NS-1:0] e, input int t);
    int bs = 0, bp = 0;
    for (int i = 1; i <= NS; i++)
      if (p[i-1] && e[i-1] && bHart[i] == h && (t == 0 || bPrio[i] < t) && (bs == 0 || bPrio[i] < bp)) begin
        bs = i; bp = bPrio[i];
      end
    return (32'(bs) << 16) | 32'(bp);
  endfunction

  function automatic int tgtAddr(input int i); return 32'h3004 + (i - 1) * 4; endfunction
  function automatic int idc(input int h, input int off); return 32'h4000 + h * 32'h20 + off; endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    logic cv;
    logic [9:0] cs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(hartIrq == '0, "R8 reset irq", 32'(hartIrq), 0);
    chk(claimValid == 1'b0, "R6 reset claim", 32'(claimValid), 0);

    // R1 target words with tied priorities
    for (int i = 1; i <= NS; i++) begin
      bPrio[i] = ((i * 5) % 3) + 1; bHart[i] = 0;
      wr(tgtAddr(i), 32'(bPrio[i]) | 32'hFF00);
    end
    for (int i = 1; i <= NS; i++) begin
      rd(tgtAddr(i), d, cv, cs);
      chk(d == 32'(bPrio[i]), "R1 target readback", d, 32'(bPrio[i]));
    end
    wr(tgtAddr(3), (32'd1 << 18) | 32'd2);
    rd(tgtAddr(3), d, cv, cs);
    chk(d == ((32'd1 << 18) | 32'd2), "R1 hart field", d, (32'd1 << 18) | 32'd2);
    wr(tgtAddr(3), 32'(bPrio[3]));

    // R2 priority zero
    wr(tgtAddr(7), 32'd0);
    rd(tgtAddr(7), d, cv, cs);
    chk(d == 32'd1, "R2 prio zero", d, 1);
    wr(tgtAddr(7), 32'(bPrio[7]));

    // R3/R5 sweep of all pending patterns
    enVec = '1;
    for (int p = 0; p < (1 << NS); p++) begin
      pendVec = NS'(p);
      rd(idc(0, 32'h18), d, cv, cs);
      e = expTop(0, NS'(p), '1, 0);
      chk(d == e, "R3 R5 topi sweep", d, e);
      chk(cv == 1'b0, "R5 topi no claim", 32'(cv), 0);
    end

    // R3 enable mask
    pendVec = '1;
    enVec = 7'b1010100;
    rd(idc(0, 32'h18), d, cv, cs);
    e = expTop(0, '1, 7'b1010100, 0);
    chk(d == e, "R3 enable mask", d, e);
    enVec = '1;

    // R4 thresholds
    for (int t = 0; t <= 4; t++) begin
      wr(idc(0, 8), 32'(t));
      for (int q = 0; q < 2; q++) begin
        pendVec = (q == 0) ? 7'h7F : 7'b0011011;
        rd(idc(0, 32'h18), d, cv, cs);
        e = expTop(0, pendVec, '1, t);
        chk(d == e, "R4 threshold", d, e);
      end
    end
    wr(idc(0, 8), 0);

    // R3 routing: odd sources to hart 1
    for (int i = 1; i <= NS; i += 2) begin
      bHart[i] = 1;
      wr(tgtAddr(i), (32'd1 << 18) | 32'(bPrio[i]));
    end
    pendVec = '1;
    for (int h = 0; h < NH; h++) begin
      rd(idc(h, 32'h18), d, cv, cs);
      e = expTop(h, '1, '1, 0);
      chk(d == e, "R3 routing", d, e);
    end

    // R9 slice layout
    wr(idc(1, 0), 1); wr(idc(1, 4), 1); wr(idc(1, 8), 32'h5A);
    rd(idc(1, 0), d, cv, cs); chk(d == 1, "R9 deliv", d, 1);
    rd(idc(1, 4), d, cv, cs); chk(d == 1, "R9 force", d, 1);
    rd(idc(1, 8), d, cv, cs); chk(d == 32'h5A, "R9 thresh", d, 32'h5A);
    rd(idc(0, 8), d, cv, cs); chk(d == 0, "R9 other hart", d, 0);
    wr(idc(1, 0), 0); wr(idc(1, 4), 0); wr(idc(1, 8), 0);

    // R8 hart lines
    wr(idc(0, 0), 1);
    @(negedge clk);
    chk(hartIrq == 2'b01, "R8 deliv gate", 32'(hartIrq), 1);
    domainEn = 1'b0;
    @(negedge clk);
    chk(hartIrq == 2'b00, "R8 domain gate", 32'(hartIrq), 0);
    domainEn = 1'b1;
    wr(idc(0, 8), 1);
    @(negedge clk);
    chk(hartIrq == 2'b00, "R8 nothing eligible", 32'(hartIrq), 0);
    wr(idc(0, 4), 1);
    @(negedge clk);
    chk(hartIrq == 2'b01, "R8 force", 32'(hartIrq), 1);
    wr(idc(0, 4), 0); wr(idc(0, 8), 0);

    // R6 claims drain hart 0 in order
    pendVec = '1;
    for (int k = 0; k < 3; k++) begin
      e = expTop(0, pendVec, '1, 0);
      rd(idc(0, 32'h1C), d, cv, cs);
      chk(d == e, "R6 claim word", d, e);
      chk(cv == 1'b1 && 32'(cs) == (e >> 16), "R6 claim strobe", 32'(cs), e >> 16);
      @(negedge clk);
      chk(claimValid == 1'b0, "R6 single pulse", 32'(claimValid), 0);
      pendVec[cs-1] = 1'b0;
    end

    // R7 empty claim clears force
    pendVec = '0;
    wr(idc(0, 4), 1);
    @(negedge clk);
    chk(hartIrq[0] == 1'b1, "R7 forced line", 32'(hartIrq), 1);
    rd(idc(0, 32'h1C), d, cv, cs);
    chk(d == 0 && cv == 1'b0, "R7 empty claim", d, 0);
    rd(idc(0, 4), d, cv, cs);
    chk(d == 0, "R7 force cleared", d, 0);
    chk(hartIrq[0] == 1'b0, "R7 line dropped", 32'(hartIrq), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule